// File: doc/BRIEF.md
# Operating Mode Clock Controller

This block decides the operating mode of a small processor core and drives one clock enable for each clock domain. A mode register holds a slow-clock select code, a fast/slow system clock choice, an idle-enable bit and a serial-bus enable bit. Two read-only ready flags sit beside these fields. The flags come from start-up timers. The high flag is set once the main oscillator has been enabled for `HI_WAIT` cycles without a break. The low flag is set `LO_WAIT` cycles after reset, because the low-frequency source never stops.

While the core runs, the register fields pick one of three run modes:
- **Normal**: the main clock drives the system clock.
- **Slow0**: the low-frequency oscillator drives the slow and system clocks, and the main oscillator is off.
- **Slow1**: a power-of-two divide of the main clock drives the slow and system clocks.

A halt request from the CPU moves the block to Idle if idle-enable is set, and to Sleep if it is clear. A wake pulse brings it back to the run mode that the register holds at that moment.

The slow clock appears at the ports as a one-cycle enable tick. For the low-oscillator codes the tick is the oscillator's own pulse. For the divide codes it comes from a free-running counter on the reference clock, and that counter restarts whenever the select code changes.

Top module: `opmode_clk_ctrl`

## Requirements
- R1: After reset the register holds slow select 000, fast select 1, idle-enable 0 and bus enable 0. `mode` reads Normal and `en_cpu` is 0 until the high ready flag is set.
- R2: `rd_data` layout:
  - bits [SEL_W-1:0] slow select
  - bit SEL_W fast select
  - bit SEL_W+1 idle-enable
  - bit SEL_W+2 bus enable
  - bit SEL_W+3 high ready flag
  - bit SEL_W+4 low ready flag

  A write with `wr_en` updates the lower four fields on the next edge and has no effect on the two flag bits. `bus_if_en` follows the bus enable bit.
- R3: `mode` encoding: 0 Normal, 1 Slow0, 2 Slow1, 3 Idle, 4 Sleep. While running, fast select 1 gives Normal. Fast select 0 with slow select 000 or 001 gives Slow0. Fast select 0 with any other slow select gives Slow1.
- R4: Enables in the run modes:
  - Normal: main, slow, sys and fs on.
  - Slow0: main off; slow, sys and fs on.
  - Slow1: main, slow, sys and fs on.
- R5: A halt request while running with idle-enable 1 gives Idle after the next edge. In Idle, main, slow, sys and cpu are off, and `en_fs` equals `cfg_fs_sub`.
- R6: A halt request while running with idle-enable 0 gives Sleep after the next edge. In Sleep, main, slow, sys, cpu and fs are all off.
- R7: In Idle or Sleep, a wake pulse returns the block, after the next edge, to the run mode given by the current register fields. Wake has no effect while running. Halt has no effect in Idle or Sleep.
- R8: `en_cpu` is set in Normal and Slow1 only when the high flag is set, and in Slow0 only when the low flag is set. The high flag clears the cycle after the main enable drops. It sets again `HI_WAIT` cycles after the main enable returns.
- R9: `en_wdt` equals `cfg_wdt_on` AND `wdt_ctl_en` in every mode.
- R10: `slow_tick` depends on the slow select code and the slow domain:
  - Codes 000 and 001: `slow_tick` passes `losc_tick` while the slow domain is on.
  - Code c from 010 to 111: `slow_tick` is a one-cycle pulse every 64 >> (c-2) cycles.
  - In Idle and Sleep, `slow_tick` stays 0.
- R11: When the select code changes to a divide code, the divider restarts. The first tick comes in the (P+1)-th cycle after the writing edge, where P is the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock, the main oscillator rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | SEL_W+5 (8) | Write data; the two flag bits are ignored |
| rd_data | output | SEL_W+5 (8) | Register contents with the ready flags |
| halt_req | input | 1 | Halt request from the CPU |
| wake | input | 1 | Wake-up pulse |
| losc_tick | input | 1 | Low-frequency oscillator pulse, already in the clk domain |
| cfg_fs_sub | input | 1 | Static choice: fS from the sub clock (1) or from fSYS/4 (0) |
| cfg_wdt_on | input | 1 | Static watchdog configuration |
| wdt_ctl_en | input | 1 | Watchdog control enable bit |
| en_main | output | 1 | Main oscillator enable |
| en_slow | output | 1 | Slow clock domain enable |
| en_sys | output | 1 | System clock enable |
| en_cpu | output | 1 | CPU clock enable |
| en_fs | output | 1 | Internal fS clock enable |
| en_wdt | output | 1 | Watchdog clock enable |
| slow_tick | output | 1 | Slow clock enable tick |
| bus_if_en | output | 1 | Serial bus interface enable |
| mode | output | 3 | Current operating mode |

## Verification
A wrong sequencer state shows on `mode` and on the enable group in the very cycle after the halt or wake edge, so the checks sample one cycle after each request. A wrong start-up timer count shows as `en_cpu` rising too early or too late after the main enable returns, and the checks bound that on both sides. A divider that fails to restart, or that matches the wrong bits, moves the first tick or the tick spacing off the expected cycle count. That error is visible within one slow period.

// File: rtl/opm_pkg.sv
package opm_pkg;
   typedef enum logic [2:0] {
      MD_NORMAL = 3'd0,
      MD_SLOW0  = 3'd1,
      MD_SLOW1  = 3'd2,
      MD_IDLE   = 3'd3,
      MD_SLEEP  = 3'd4
   } opmode_e;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_IDLE  = 2'd1,
      ST_SLEEP = 2'd2
   } seq_state_e;
endpackage

// File: rtl/opm_startup_timer.sv
module opm_startup_timer #(
   parameter int WAIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic ready
);
   localparam int CW = $clog2(WAIT + 1);
   localparam logic [CW-1:0] LIMIT = CW'(WAIT);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run)            cnt_q <= '0;
      else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
   end

   assign ready = (cnt_q == LIMIT);

   // R8
   rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !ready);
endmodule

// File: rtl/opm_slow_div.sv
module opm_slow_div #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             active,
   input  logic             slow_on,
   input  logic             losc_tick,
   output logic             tick
);
   localparam int NCODE = 2 ** SEL_W;
   localparam int CNT_W = NCODE - 2;

   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic [NCODE-1:0] hit;
   logic             chg, use_losc, div_pulse;

   assign chg      = (sel != sel_q);
   assign use_losc = (sel < SEL_W'(2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         cnt_q <= '0;
      end else begin
         sel_q <= sel;
         if (chg || !active) cnt_q <= '0;
         else                cnt_q <= cnt_q + 1'b1;
      end
   end

   // codes 0 and 1 take the low oscillator; code c uses the low (NCODE-c) bits
   assign hit[1:0] = 2'b00;
   for (genvar c = 2; c < NCODE; c++) begin : g_code
      localparam int K = NCODE - c;
      assign hit[c] = &cnt_q[K-1:0];
   end

   assign div_pulse = slow_on && active && !use_losc && !chg && hit[sel];
   assign tick      = use_losc ? (slow_on && losc_tick) : div_pulse;

   // R10
   div_tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);
endmodule

// File: rtl/opm_mode_seq.sv
module opm_mode_seq
   import opm_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    halt_req,
   input  logic    wake,
   input  logic    fast_sel,
   input  logic    idle_en,
   input  logic    slow_lo,
   input  logic    hi_rdy,
   input  logic    lo_rdy,
   input  logic    cfg_fs_sub,
   input  logic    wdt_on,
   output opmode_e mode,
   output logic    en_main,
   output logic    en_slow,
   output logic    en_sys,
   output logic    en_cpu,
   output logic    en_fs,
   output logic    en_wdt
);
   seq_state_e st_q, st_d;
   opmode_e    run_mode;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN:   if (halt_req) st_d = idle_en ? ST_IDLE : ST_SLEEP;
         ST_IDLE,
         ST_SLEEP: if (wake) st_d = ST_RUN;
         default:  st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_RUN;
      else        st_q <= st_d;
   end

   always_comb begin
      if (fast_sel)     run_mode = MD_NORMAL;
      else if (slow_lo) run_mode = MD_SLOW0;
      else              run_mode = MD_SLOW1;
      unique case (st_q)
         ST_IDLE:  mode = MD_IDLE;
         ST_SLEEP: mode = MD_SLEEP;
         default:  mode = run_mode;
      endcase
   end

   always_comb begin
      en_main = 1'b0;
      en_slow = 1'b0;
      en_sys  = 1'b0;
      en_cpu  = 1'b0;
      en_fs   = 1'b0;
      en_wdt  = wdt_on;
      unique case (mode)
         MD_NORMAL, MD_SLOW1: begin
            en_main = 1'b1;
            en_slow = 1'b1;
            en_sys  = 1'b1;
            en_cpu  = hi_rdy;
            en_fs   = 1'b1;
         end
         MD_SLOW0: begin
            en_slow = 1'b1;
            en_sys  = 1'b1;
            en_cpu  = lo_rdy;
            en_fs   = 1'b1;
         end
         MD_IDLE:  en_fs = cfg_fs_sub;
         default:  en_fs = 1'b0;
      endcase
   end

   // R5
   halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && halt_req && idle_en) |=> (st_q == ST_IDLE));
   // R6
   halt_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && halt_req && !idle_en) |=> (st_q == ST_SLEEP));
   // R7
   wake_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_RUN && wake) |=> (st_q == ST_RUN));
   // R6
   sleep_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SLEEP) |-> !(en_main || en_slow || en_sys || en_cpu || en_fs));
endmodule

// File: rtl/opmode_clk_ctrl.sv
module opmode_clk_ctrl
   import opm_pkg::*;
#(
   parameter int SEL_W   = 3,
   parameter int HI_WAIT = 16,
   parameter int LO_WAIT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SEL_W+4:0]   wr_data,
   output logic [SEL_W+4:0]   rd_data,
   input  logic               halt_req,
   input  logic               wake,
   input  logic               losc_tick,
   input  logic               cfg_fs_sub,
   input  logic               cfg_wdt_on,
   input  logic               wdt_ctl_en,
   output logic               en_main,
   output logic               en_slow,
   output logic               en_sys,
   output logic               en_cpu,
   output logic               en_fs,
   output logic               en_wdt,
   output logic               slow_tick,
   output logic               bus_if_en,
   output logic [2:0]         mode
);
   localparam int B_FAST = SEL_W;
   localparam int B_IDLE = SEL_W + 1;
   localparam int B_BUS  = SEL_W + 2;
   localparam int B_HRDY = SEL_W + 3;
   localparam int B_LRDY = SEL_W + 4;

   if (SEL_W < 2 || SEL_W > 4) begin : g_bad_sel
      $error("SEL_W must be between 2 and 4");
   end
   if (HI_WAIT < 1 || LO_WAIT < 1) begin : g_bad_wait
      $error("start-up waits must be at least 1");
   end

   logic [SEL_W-1:0] sel_q;
   logic             fast_q, idle_q, bus_q;
   logic             hi_rdy, lo_rdy;
   opmode_e          mode_e;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         fast_q <= 1'b1;
         idle_q <= 1'b0;
         bus_q  <= 1'b0;
      end else if (wr_en) begin
         sel_q  <= wr_data[SEL_W-1:0];
         fast_q <= wr_data[B_FAST];
         idle_q <= wr_data[B_IDLE];
         bus_q  <= wr_data[B_BUS];
      end
   end

   assign rd_data   = {lo_rdy, hi_rdy, bus_q, idle_q, fast_q, sel_q};
   assign bus_if_en = bus_q;
   assign mode      = mode_e;

   opm_startup_timer #(.WAIT(HI_WAIT)) i_hi_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en_main),
      .ready (hi_rdy)
   );

   opm_startup_timer #(.WAIT(LO_WAIT)) i_lo_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (1'b1),
      .ready (lo_rdy)
   );

   opm_mode_seq i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt_req   (halt_req),
      .wake       (wake),
      .fast_sel   (fast_q),
      .idle_en    (idle_q),
      .slow_lo    (sel_q < SEL_W'(2)),
      .hi_rdy     (hi_rdy),
      .lo_rdy     (lo_rdy),
      .cfg_fs_sub (cfg_fs_sub),
      .wdt_on     (cfg_wdt_on && wdt_ctl_en),
      .mode       (mode_e),
      .en_main    (en_main),
      .en_slow    (en_slow),
      .en_sys     (en_sys),
      .en_cpu     (en_cpu),
      .en_fs      (en_fs),
      .en_wdt     (en_wdt)
   );

   opm_slow_div #(.SEL_W(SEL_W)) i_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel_q),
      .active    (en_main),
      .slow_on   (en_slow),
      .losc_tick (losc_tick),
      .tick      (slow_tick)
   );

   // R8
   cpu_needs_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_cpu |-> en_sys);
endmodule

// File: tb/test_opmode_clk_ctrl.sv
module test_opmode_clk_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       halt_req = 1'b0, wake = 1'b0, losc_tick = 1'b0;
   logic       cfg_fs_sub = 1'b1, cfg_wdt_on = 1'b1, wdt_ctl_en = 1'b0;
   logic       en_main, en_slow, en_sys, en_cpu, en_fs, en_wdt, slow_tick, bus_if_en;
   logic [2:0] mode;
   int         n_cmp = 0, n_bad = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   opmode_clk_ctrl i_opmode_clk_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .halt_req(halt_req), .wake(wake), .losc_tick(losc_tick), .cfg_fs_sub(cfg_fs_sub),
      .cfg_wdt_on(cfg_wdt_on), .wdt_ctl_en(wdt_ctl_en), .en_main(en_main),
      .en_slow(en_slow), .en_sys(en_sys), .en_cpu(en_cpu), .en_fs(en_fs),
      .en_wdt(en_wdt), .slow_tick(slow_tick), .bus_if_en(bus_if_en), .mode(mode)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_en(input string tag, input logic [5:0] exp);
      chk(tag, {26'd0, en_main, en_slow, en_sys, en_cpu, en_fs, en_wdt}, {26'd0, exp});
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic pulse_halt();
      @(negedge clk); halt_req = 1'b1;
      @(negedge clk); halt_req = 1'b0;
   endtask

   task automatic pulse_wake();
      @(negedge clk); wake = 1'b1;
      @(negedge clk); wake = 1'b0;
   endtask

   task automatic t_reset();
      cyc(3); rst_n = 1'b1;
      chk("R1 reset mode", mode, 0);
      chk("R1 reset register", rd_data, 8'h08);
      chk("R1 cpu held before ready", en_cpu, 0);
      chk("R2 bus enable reset", bus_if_en, 0);
      cyc(20);
      chk("R8 cpu after start-up", en_cpu, 1);
      chk("R2 flags set after start-up", rd_data, 8'hC8);
      chk_en("R4 normal enables", 6'b111110);
   endtask

   task automatic t_readback();
      wr(8'h2C);
      chk("R2 bus bit follows write", bus_if_en, 1);
      chk("R2 readback of fields", rd_data, 8'hEC);
      wr(8'hC0);
      cyc(1);
      chk("R2 flag bits not writable", rd_data, 8'h80);
      chk("R3 slow0 decode", mode, 1);
   endtask

   task automatic t_run_modes();
      wr(8'h00);
      chk("R3 slow0 mode", mode, 1);
      chk_en("R4 slow0 enables", 6'b011110);
      wr(8'h07);
      chk("R3 slow1 mode", mode, 2);
      chk_en("R8 slow1 cpu waits for high flag", 6'b111010);
      cyc(20);
      chk_en("R4 slow1 enables", 6'b111110);
      wr(8'h09);
      chk("R3 normal mode with code 1", mode, 0);
   endtask

   task automatic t_idle();
      wr(8'h18); cyc(20);
      cfg_fs_sub = 1'b1;
      pulse_halt();
      chk("R5 idle mode", mode, 3);
      chk_en("R5 idle enables with fs from sub", 6'b000010);
      cfg_fs_sub = 1'b0; #1;
      chk_en("R5 idle enables with fs from sys", 6'b000000);
      cfg_fs_sub = 1'b1;
      wr(8'h08);
      pulse_halt();
      chk("R7 halt ignored in idle", mode, 3);
      pulse_wake();
      chk("R7 wake returns to normal", mode, 0);
      chk_en("R8 cpu off right after wake", 6'b111010);
      cyc(12);
      chk("R8 cpu still waiting", en_cpu, 0);
      cyc(6);
      chk("R8 cpu after wait", en_cpu, 1);
   endtask

   task automatic t_sleep();
      pulse_wake();
      chk("R7 wake ignored while running", mode, 0);
      pulse_halt();
      chk("R6 sleep mode", mode, 4);
      chk_en("R6 sleep enables", 6'b000000);
      losc_tick = 1'b1; #1;
      chk("R10 no tick in sleep", slow_tick, 0);
      @(negedge clk); losc_tick = 1'b0;
      wdt_ctl_en = 1'b1; #1;
      chk("R9 watchdog in sleep", en_wdt, 1);
      wr(8'h01);
      pulse_wake();
      chk("R7 wake into slow0 from register", mode, 1);
      chk("R8 slow0 cpu uses low flag", en_cpu, 1);
      chk("R9 watchdog in slow0", en_wdt, 1);
      cfg_wdt_on = 1'b0; #1;
      chk("R9 watchdog config off", en_wdt, 0);
      cfg_wdt_on = 1'b1; wdt_ctl_en = 1'b0;
   endtask

   task automatic t_losc();
      wr(8'h00);
      losc_tick = 1'b1; #1;
      chk("R10 low osc tick passes", slow_tick, 1);
      @(negedge clk); losc_tick = 1'b0; #1;
      chk("R10 low osc tick low", slow_tick, 0);
   endtask

   task automatic t_div();
      for (int c = 2; c < 8; c++) begin
         int per = 64 >> (c - 2);
         int n = 1;
         int gap = 0;
         wr(8'(c));
         while (!slow_tick && n < 200) begin @(negedge clk); n++; end
         chk($sformatf("R11 first tick code %0d", c), n, per + 1);
         @(negedge clk); gap = 1;
         chk($sformatf("R10 tick one cycle code %0d", c), slow_tick, 0);
         while (!slow_tick && gap < 200) begin @(negedge clk); gap++; end
         chk($sformatf("R10 tick period code %0d", c), gap, per);
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_readback();
      t_run_modes();
      t_idle();
      t_sleep();
      t_losc();
      t_div();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule